// File: doc/BRIEF.md
# Line Transceiver Interrupt Status Register

This block holds the four interrupt flags of a line transceiver, plus a mask that gates them onto one interrupt request. Each flag has its own rule for setting and clearing. The level-detect flag copies, one clock late, whether any receive signal is present on the line. The info-change flag latches whenever the receiver-status word (info code plus code-violation flag) differs from its value in the previous clock. The channel-change flag latches on a strobe from the S/Q code extractor. The channel-writable flag latches at every multiframe boundary.

Software reaches the block over a simple register bus with separate read and write strobes. Reading the status register clears nothing. The latched flags clear as side effects of accesses to neighbouring registers:
- info-change clears on a read of the transceiver-status register;
- channel-change clears on a read of any of the S/Q receive registers;
- channel-writable clears on a write to any of the S/Q transmit registers.

Read data and the interrupt request are registered outputs.

Top module: `xcvr_irq_status`

## Requirements
- R1: Synchronous active-high reset:
  - clears all four status flags;
  - clears read data and the interrupt request to 0;
  - loads the mask register with 0xFF, so all sources are masked.
- R2: A read of the status register (address 0) returns bit 3 = level detect, bit 2 = info change, bit 1 = channel change, bit 0 = channel writable, with bits 7..4 always 0. A write to address 0 has no effect on the flags.
- R3: The level-detect flag equals the line-signal input sampled at the previous clock edge. It is a live level, not latched.
- R4: The info-change flag sets at the first clock edge where the receiver-status word {violation, info code} differs from its value at the previous edge. It stays set until cleared.
- R5: The info-change flag is cleared by a read of the transceiver-status register (address 2). Reads of the status register do not clear it.
- R6: The channel-change flag sets on a clock edge where the channel-change strobe is high. It is cleared by a read of any of the three receive registers (addresses 3, 4, 5). Reads of the transmit registers do not clear it.
- R7: The channel-writable flag sets on a clock edge where the multiframe strobe is high. It is cleared by a write to any of the three transmit registers (addresses 6, 7, 8). Reads of those addresses do not clear it.
- R8: When a flag's set event and its clearing access fall on the same clock edge, the flag ends set.
- R9: The mask register (address 1) is 8 bits wide, read/write, and uses the status bit layout. A mask bit of 1 keeps the flag out of the interrupt request, but the flag itself still sets and reads back.
- R10: The interrupt request is the OR over bits 3..0 of (status AND NOT mask), registered: it reflects the flags and mask present one clock edge earlier.
- R11: Read data is registered. It appears the clock edge after the read strobe.
  - A read of address 2 returns {violation, info code}, with the violation flag at bit 4 for the default 4-bit info code, zero-extended.
  - Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| line_sig | input | 1 | High while any receive signal is present on the line |
| rx_info | input | INFO_W (4) | Received info code from the receiver-status word |
| rx_viol | input | 1 | Code-violation flag from the receiver-status word |
| sq_chg | input | 1 | Strobe: new S/Q receive code detected |
| mf_tick | input | 1 | Strobe: multiframe boundary |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered, active-high interrupt request |
| mask | output | 8 | Current mask register value |

## Verification
The bench walks the receiver-status word through every one of its 32 values. After each step it confirms that the info-change flag sets, survives a status read, and clears only on the transceiver-status read. A design that cleared on the wrong access, or missed a violation-only change, shows a stale or missing flag.

The bench puts each set event on the same edge as its clearing access. A design in which the clear wins would drop the event.

All 16 mask nibbles are swept with every flag set, and a single-source case checks the one-cycle request latency. A design that gated the flags instead of the request, or used a combinational request, is caught there.

Clearing accesses to the neighbouring addresses are also tested. A decoder that confused receive, transmit or status addresses would clear the wrong flag.

// File: rtl/xis_pkg.sv
package xis_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 4;
  localparam int STICKY_N = 3;
  // flag bit positions in the status and mask registers
  localparam int B_LD  = 3;
  localparam int B_RIC = 2;
  localparam int B_SQC = 1;
  localparam int B_SQW = 0;

  typedef struct packed {
    logic rd_stat;
    logic rd_mask;
    logic wr_mask;
    logic rd_trsta;
    logic rd_sqr;
    logic wr_sqx;
  } acc_t;
endpackage

// File: rtl/xis_bus_decode.sv
module xis_bus_decode #(
  parameter int ADDR_W     = 4,
  parameter int SQ_REGS    = 3,
  parameter int STAT_ADDR  = 0,
  parameter int MASK_ADDR  = 1,
  parameter int TRSTA_ADDR = 2,
  parameter int SQR_BASE   = 3,
  parameter int SQX_BASE   = 6
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output xis_pkg::acc_t     acc
);
  logic [SQ_REGS-1:0] sqr_hit;
  logic [SQ_REGS-1:0] sqx_hit;

  for (genvar i = 0; i < SQ_REGS; i++) begin : g_sq
    assign sqr_hit[i] = (bus_addr == ADDR_W'(SQR_BASE + i));
    assign sqx_hit[i] = (bus_addr == ADDR_W'(SQX_BASE + i));
  end

  always_comb begin
    acc.rd_stat  = bus_rd && (bus_addr == ADDR_W'(STAT_ADDR));
    acc.rd_mask  = bus_rd && (bus_addr == ADDR_W'(MASK_ADDR));
    acc.wr_mask  = bus_wr && (bus_addr == ADDR_W'(MASK_ADDR));
    acc.rd_trsta = bus_rd && (bus_addr == ADDR_W'(TRSTA_ADDR));
    acc.rd_sqr   = bus_rd && (|sqr_hit);
    acc.wr_sqx   = bus_wr && (|sqx_hit);
  end
endmodule

// File: rtl/xis_change_det.sv
module xis_change_det #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  output logic         chg
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= cur;
      primed_q <= 1'b1;
    end
  end

  // first cycle after reset only captures the reference value
  assign chg = primed_q && (cur != prev_q);

  // R4: a stable word never reports a change
  a_r4_stable_no_change: assert property (@(posedge clk) disable iff (rst)
    (primed_q && $stable(cur)) |-> !chg);
endmodule

// File: rtl/xis_sticky_flag.sv
module xis_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr_ev) flag <= 1'b0;
  end

  // R8: an event on the same edge as its clear is kept
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> flag);
  a_r8_clear_alone: assert property (@(posedge clk) disable iff (rst)
    (clr_ev && !set_ev) |=> !flag);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_ev && !set_ev) |=> (flag == $past(flag)));
endmodule

// File: rtl/xcvr_irq_status.sv
module xcvr_irq_status #(
  parameter int          ADDR_W     = 4,
  parameter int          INFO_W     = 4,
  parameter int          SQ_REGS    = 3,
  parameter int          STAT_ADDR  = 0,
  parameter int          MASK_ADDR  = 1,
  parameter int          TRSTA_ADDR = 2,
  parameter int          SQR_BASE   = 3,
  parameter int          SQX_BASE   = 6,
  parameter logic [7:0]  MASK_RST   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              line_sig,
  input  logic [INFO_W-1:0] rx_info,
  input  logic              rx_viol,
  input  logic              sq_chg,
  input  logic              mf_tick,
  output logic [7:0]        rdata,
  output logic              irq,
  output logic [7:0]        mask
);
  import xis_pkg::*;

  localparam int RSW_W = INFO_W + 1;

  acc_t                  acc;
  logic                  info_chg;
  logic [STICKY_N-1:0]   set_v;
  logic [STICKY_N-1:0]   clr_v;
  logic [STICKY_N-1:0]   sticky_q;
  logic                  ld_q;
  logic [STAT_W-1:0]     stat;
  logic [DATA_W-1:0]     mask_q;
  logic [DATA_W-1:0]     rdata_q;
  logic [DATA_W-1:0]     rd_mux;
  logic                  irq_q;

  xis_bus_decode #(
    .ADDR_W(ADDR_W), .SQ_REGS(SQ_REGS), .STAT_ADDR(STAT_ADDR),
    .MASK_ADDR(MASK_ADDR), .TRSTA_ADDR(TRSTA_ADDR),
    .SQR_BASE(SQR_BASE), .SQX_BASE(SQX_BASE)
  ) u_dec (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .acc(acc)
  );

  xis_change_det #(.W(RSW_W)) u_chg (
    .clk(clk), .rst(rst), .cur({rx_viol, rx_info}), .chg(info_chg)
  );

  // set and clear sources indexed by status bit position
  always_comb begin
    set_v[B_SQW] = mf_tick;
    clr_v[B_SQW] = acc.wr_sqx;
    set_v[B_SQC] = sq_chg;
    clr_v[B_SQC] = acc.rd_sqr;
    set_v[B_RIC] = info_chg;
    clr_v[B_RIC] = acc.rd_trsta;
  end

  for (genvar b = 0; b < STICKY_N; b++) begin : g_flag
    xis_sticky_flag u_flag (
      .clk(clk), .rst(rst), .set_ev(set_v[b]), .clr_ev(clr_v[b]),
      .flag(sticky_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ld_q <= 1'b0;
    else     ld_q <= line_sig;
  end

  assign stat = {ld_q, sticky_q};

  always_ff @(posedge clk) begin
    if (rst)              mask_q <= MASK_RST;
    else if (acc.wr_mask) mask_q <= bus_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (acc.rd_stat)  rd_mux = DATA_W'(stat);
    if (acc.rd_mask)  rd_mux = mask_q;
    if (acc.rd_trsta) rd_mux = DATA_W'({rx_viol, rx_info});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_mux;
      irq_q <= |(stat & ~mask_q[STAT_W-1:0]);
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
  assign mask  = mask_q;

  // R3: level flag tracks the line one edge late
  a_r3_level_live: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat[B_LD] == $past(line_sig)));
  // R2: reserved bits of a status read are zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    acc.rd_stat |=> (rdata[7:STAT_W] == '0));
  // R10: request follows flags and mask of the previous edge
  a_r10_irq_registered: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(stat) & ~$past(mask_q[STAT_W-1:0]))));
  // R9: a fully masked source set never raises the request
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q[STAT_W-1:0] == '1 && !acc.wr_mask) |=> !irq);
endmodule

// File: tb/test_xcvr_irq_status.sv
module test_xcvr_irq_status;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata;
  logic       line_sig;
  logic [3:0] rx_info;
  logic       rx_viol;
  logic       sq_chg, mf_tick;
  logic [7:0] rdata, mask;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xcvr_irq_status i_xcvr_irq_status (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .line_sig(line_sig),
    .rx_info(rx_info), .rx_viol(rx_viol), .sq_chg(sq_chg),
    .mf_tick(mf_tick), .rdata(rdata), .irq(irq), .mask(mask)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic pulse_sq();
    sq_chg = 1'b1; tick(); sq_chg = 1'b0;
  endtask

  task automatic pulse_mf();
    mf_tick = 1'b1; tick(); mf_tick = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [4:0] prev;
    rst = 1'b1; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    line_sig = 0; rx_info = '0; rx_viol = 0; sq_chg = 0; mf_tick = 0;
    repeat (5) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 mask port", mask, 8'hFF);
    rd(4'd1, d); chk("R1 mask read", d, 8'hFF);
    rd(4'd0, d); chk("R1 status", d, 8'h00);

    // R3 level detect follows the line, not latched
    for (int k = 0; k < 6; k++) begin
      line_sig = k[0] ^ k[1];
      tick();
      rd(4'd0, d); chk("R3 level", d, {4'd0, line_sig, 3'b000});
    end
    line_sig = 1'b0; tick();

    // R4, R5, R11: sweep all receiver-status words
    prev = 5'd0;
    for (int v = 1; v < 32; v++) begin
      {rx_viol, rx_info} = 5'(v);
      tick();
      rd(4'd0, d); chk("R4 info change set", d & 8'h04, 8'h04);
      rd(4'd0, d); chk("R5 status read keeps flag", d & 8'h04, 8'h04);
      rd(4'd2, d); chk("R11 transceiver status value", d, 8'(v));
      rd(4'd0, d); chk("R5 cleared by transceiver read", d & 8'h04, 8'h00);
      prev = 5'(v);
    end
    chk("R4 sweep end", {3'd0, prev}, 8'h1F);
    // violation-only change
    rx_viol = 1'b0; tick();
    rd(4'd0, d); chk("R4 violation-only change", d & 8'h04, 8'h04);
    rd(4'd2, d);

    // R6 channel change, cleared by each receive register
    for (int i = 0; i < 3; i++) begin
      pulse_sq();
      rd(4'd0, d); chk("R6 set", d & 8'h02, 8'h02);
      rd(4'(6 + i), d); chk("R6 transmit read keeps", 8'(rdata), 8'h00);
      rd(4'd0, d); chk("R6 kept after transmit read", d & 8'h02, 8'h02);
      rd(4'(3 + i), d);
      rd(4'd0, d); chk("R6 cleared by receive read", d & 8'h02, 8'h00);
    end

    // R7 writable, cleared by each transmit register write
    for (int i = 0; i < 3; i++) begin
      pulse_mf();
      rd(4'd0, d); chk("R7 set", d & 8'h01, 8'h01);
      rd(4'(6 + i), d);
      rd(4'd0, d); chk("R7 kept after transmit read", d & 8'h01, 8'h01);
      wr(4'(6 + i), 8'h5A);
      rd(4'd0, d); chk("R7 cleared by transmit write", d & 8'h01, 8'h00);
    end

    // R8 set wins on the same edge
    sq_chg = 1'b1; bus_addr = 4'd4; bus_rd = 1'b1; tick();
    sq_chg = 1'b0; bus_rd = 1'b0;
    rd(4'd0, d); chk("R8 channel change kept", d & 8'h02, 8'h02);
    mf_tick = 1'b1; bus_addr = 4'd7; bus_wdata = 8'h00; bus_wr = 1'b1; tick();
    mf_tick = 1'b0; bus_wr = 1'b0;
    rd(4'd0, d); chk("R8 writable kept", d & 8'h01, 8'h01);
    rx_info = rx_info + 4'd1; bus_addr = 4'd2; bus_rd = 1'b1; tick();
    bus_rd = 1'b0;
    rd(4'd0, d); chk("R8 info change kept", d & 8'h04, 8'h04);

    // R2 status write ignored, unmapped read is zero
    wr(4'd0, 8'h00);
    rd(4'd0, d); chk("R2 write ignored", d, 8'h07);
    rd(4'd15, d); chk("R11 unmapped", d, 8'h00);

    // R9, R10 mask sweep with all flags set
    line_sig = 1'b1; tick();
    for (int m = 0; m < 16; m++) begin
      wr(4'd1, {4'hA, 4'(m)});
      tick();
      chk("R10 irq vs mask", {7'd0, irq}, {7'd0, ((~m) & 15) != 0});
      rd(4'd1, d); chk("R9 mask readback", d, {4'hA, 4'(m)});
      rd(4'd0, d); chk("R9 flags still set", d, 8'h0F);
    end

    // R10 single-source latency
    line_sig = 1'b0;
    rd(4'd2, d); rd(4'd3, d); wr(4'd6, 8'h00);
    wr(4'd1, 8'h00);
    tick(); tick();
    chk("R10 idle irq", {7'd0, irq}, 8'h00);
    pulse_mf();
    chk("R10 one-cycle lag", {7'd0, irq}, 8'h00);
    tick();
    chk("R10 raised", {7'd0, irq}, 8'h01);
    wr(4'd8, 8'h00);
    tick();
    chk("R10 dropped after clear", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule